// File: doc/BRIEF.md
# Dual-Order Four-Beat Burst Address Sequencer

This block turns one supplied start address into a burst of up to four consecutive accesses. On every rising clock edge a single active-low control, `load_n`, picks one of two actions. Held low, it captures a new start address, the chip-enable vector and the write enable, and begins a new access. The access is started only when every chip enable is high; otherwise the sequencer becomes deselected. Held high, it steps an active burst to its next beat. While stepping, the chip enables and the write enable are not looked at.

Only the two low address bits move during a burst. A static order input chooses how they move:
- **Linear order** (order input low): the two bits count up and wrap modulo four.
- **Interleaved order** (order input high): beat k uses the start bits XOR k.

The outputs are the current full address, the beat index, an access-valid flag and the read/write command held for the whole burst.

The controller is a five-state machine:
- **ST_IDLE**: no access in progress.
- **ST_BEAT0** to **ST_BEAT3**: one state per beat.

Its transitions are:
- **LOAD_SEL**: any state goes to ST_BEAT0 on a load with all enables high.
- **LOAD_DESEL**: any state goes to ST_IDLE on a load with any enable low.
- **STEP**: ST_BEATn goes to ST_BEAT(n+1), and ST_BEAT3 goes back to ST_BEAT0.
- **IDLE_HOLD**: ST_IDLE stays in ST_IDLE on an advance.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `acc_valid` is 0, `acc_write` is 0, `acc_beat` is 0 and `acc_addr` is 0.
- R2: A clock edge with `load_n`=0 and every bit of `ce_in` at 1 makes, from that edge on, `acc_valid`=1, `acc_beat`=0, `acc_addr` equal to the sampled `addr_in`, and `acc_write` equal to the sampled `we_in` (1 = write, 0 = read). This holds even in the middle of a burst.
- R3: A clock edge with `load_n`=0 and any bit of `ce_in` at 0 makes `acc_valid`=0 and `acc_write`=0 from that edge on.
- R4: A clock edge with `load_n`=1 while `acc_valid`=1 increments `acc_beat` by one modulo 4 and leaves `acc_addr` bits above bit 1 unchanged.
- R5: With `order_sel`=0 (linear), `acc_addr[1:0]` equals (start bits + `acc_beat`) mod 4; for example start 01 gives 01, 10, 11, 00.
- R6: With `order_sel`=1 (interleaved), `acc_addr[1:0]` equals start bits XOR `acc_beat`; for example start 10 gives 10, 11, 00, 01.
- R7: While advancing, the values of `ce_in` and `we_in` have no effect: `acc_valid` stays 1 and `acc_write` keeps its loaded value.
- R8: Advancing from beat 3 returns to beat 0, so `acc_addr` is again the start address and the access stays valid.
- R9: Advancing while `acc_valid`=0 has no effect: `acc_valid` stays 0 and `acc_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_n | input | 1 | 0 = load new start address, 1 = advance burst |
| ce_in | input | NUM_CE | Chip enables, all high to select |
| we_in | input | 1 | Write enable sampled at load (1 = write) |
| order_sel | input | 1 | Static order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start address sampled at load |
| acc_valid | output | 1 | An access is active this beat |
| acc_write | output | 1 | Active access is a write |
| acc_beat | output | 2 | Beat index within the burst |
| acc_addr | output | ADDR_W | Full address of the current beat |

## Verification
The hardest case to reach is the wrap after a fourth advance in which the chip enables are low and the write enable is flipped on that very edge. Here R7 and R8 meet, and a sequencer that wrongly samples either input would drop or corrupt the access.

The stimulus places exactly such an advance on beat 3 in both orders. It also sweeps all four start values in both orders. Between bursts it inserts deselecting loads followed by idle advances, so that held state is checked when nothing should move.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } burst_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              selected,
    output logic              capture,
    output logic              active,
    output logic [BEAT_W-1:0] beat
);

    burst_state_e state_q;
    burst_state_e state_d;

    // Next-state decision: a load always wins, an advance only steps beats
    always_comb begin
        state_d = state_q;
        if (!load_n) begin
            state_d = selected ? ST_BEAT0 : ST_IDLE;   // LOAD_SEL / LOAD_DESEL
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;           // IDLE_HOLD
                ST_BEAT0: state_d = ST_BEAT1;          // STEP
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;          // STEP with wrap
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the state register
    always_comb begin
        active = 1'b0;
        beat   = '0;
        unique case (state_q)
            ST_IDLE:  begin active = 1'b0; beat = 2'd0; end
            ST_BEAT0: begin active = 1'b1; beat = 2'd0; end
            ST_BEAT1: begin active = 1'b1; beat = 2'd1; end
            ST_BEAT2: begin active = 1'b1; beat = 2'd2; end
            ST_BEAT3: begin active = 1'b1; beat = 2'd3; end
            default:  begin active = 1'b0; beat = 2'd0; end
        endcase
    end

    assign capture = ~load_n & selected;

endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              we_in,
    output logic [ADDR_W-1:0] start_addr,
    output logic              write_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr <= '0;
            write_flag <= 1'b0;
        end else if (capture) begin
            start_addr <= addr_in;
            write_flag <= we_in;
        end
    end

endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_addr_pkg::*;
(
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear ordering: add and drop the carry out of the top bit
    assign lin_low = start_low + beat;

    // Interleaved ordering: bitwise XOR, one gate per bit
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low[b] ^ beat[b];
    end

    always_comb begin
        unique case (burst_order_e'(order_sel))
            ORD_LINEAR:     low_out = lin_low;
            ORD_INTERLEAVE: low_out = ilv_low;
            default:        low_out = lin_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NUM_CE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [NUM_CE-1:0] ce_in,
    input  logic              we_in,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [1:0]        acc_beat,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              selected;
    logic              capture;
    logic              active;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] start_addr;
    logic              write_flag;
    logic [BEAT_W-1:0] low_bits;

    assign selected = &ce_in;

    burst_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .selected (selected),
        .capture  (capture),
        .active   (active),
        .beat     (beat)
    );

    burst_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .addr_in    (addr_in),
        .we_in      (we_in),
        .start_addr (start_addr),
        .write_flag (write_flag)
    );

    burst_order u_ord (
        .start_low (start_addr[BEAT_W-1:0]),
        .beat      (beat),
        .order_sel (order_sel),
        .low_out   (low_bits)
    );

    assign acc_valid = active;
    assign acc_write = active & write_flag;
    assign acc_beat  = beat;
    assign acc_addr  = {start_addr[ADDR_W-1 -: HI_W], low_bits};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int NUM_CE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic [NUM_CE-1:0] ce_in,
    input logic              we_in,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_beat,
    input logic [ADDR_W-1:0] acc_addr
);

    assert_load_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && (&ce_in)) |=> (acc_valid && acc_beat == 2'd0
                                   && acc_addr == $past(addr_in)
                                   && acc_write == $past(we_in)));

    assert_load_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !(&ce_in)) |=> (!acc_valid && !acc_write));

    assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && acc_valid) |=> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])
                                   && acc_beat == 2'($past(acc_beat) + 2'd1)));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && acc_valid && !order_sel) |=> (order_sel ||
            acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

    assert_ilv_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && acc_valid && order_sel) |=> (!order_sel ||
            (acc_addr[1:0] ^ $past(acc_addr[1:0])) == (acc_beat ^ $past(acc_beat))));

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && acc_valid) |=> (acc_valid && acc_write == $past(acc_write)));

    assert_idle_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !acc_valid) |=> (!acc_valid && $stable(acc_addr)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .NUM_CE(NUM_CE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .ce_in     (ce_in),
    .we_in     (we_in),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_beat  (acc_beat),
    .acc_addr  (acc_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int NUM_CE     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1;
    logic [NUM_CE-1:0] ce_in = '0;
    logic              we_in = 1'b0;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              acc_valid;
    logic              acc_write;
    logic [1:0]        acc_beat;
    logic [ADDR_W-1:0] acc_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state
    int m_valid = 0;
    int m_write = 0;
    int m_beat  = 0;
    int m_base  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .NUM_CE(NUM_CE)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .ce_in     (ce_in),
        .we_in     (we_in),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_beat  (acc_beat),
        .acc_addr  (acc_addr)
    );

    function automatic int exp_addr();
        int lo;
        int s;
        s = m_base % 4;
        if (order_sel) lo = s ^ m_beat;
        else           lo = (s + m_beat) % 4;
        return (m_base - s) + lo;
    endfunction

    task automatic compare(input string tag);
        int ea;
        ea = exp_addr();
        n_tests++;
        if (int'(acc_valid) != m_valid || int'(acc_write) != (m_valid ? m_write : 0) ||
            int'(acc_beat) != (m_valid ? m_beat : 0) || int'(acc_addr) != ea) begin
            n_fail++;
            $display("FAIL %s: actual v=%0d w=%0d beat=%0d addr=%05h expected v=%0d w=%0d beat=%0d addr=%05h",
                     tag, acc_valid, acc_write, acc_beat, acc_addr,
                     m_valid, m_valid ? m_write : 0, m_valid ? m_beat : 0, ea);
        end
    endtask

    // One clock: drive inputs, update the reference at the edge, compare at negedge
    task automatic cyc(input logic ld_n, input logic [NUM_CE-1:0] ce,
                       input logic we, input int addr, input string tag);
        load_n  = ld_n;
        ce_in   = ce;
        we_in   = we;
        addr_in = ADDR_W'(addr);
        @(posedge clk);
        if (!ld_n) begin
            if (&ce) begin
                m_valid = 1; m_beat = 0; m_base = addr; m_write = int'(we);
            end else begin
                m_valid = 0; m_beat = 0;
            end
        end else if (m_valid != 0) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // Linear burst from low bits 01, read
        order_sel = 1'b0;
        cyc(1'b0, 3'b111, 1'b0, 20'h12345, "R2 load linear");
        cyc(1'b1, 3'b111, 1'b0, 0, "R5 linear beat1");
        cyc(1'b1, 3'b000, 1'b1, 20'hFFFFF, "R4 R7 beat2 upper hold");
        cyc(1'b1, 3'b010, 1'b1, 0, "R5 R7 beat3");
        cyc(1'b1, 3'b000, 1'b1, 20'h00000, "R8 R7 wrap linear");
        cyc(1'b1, 3'b111, 1'b1, 0, "R8 post-wrap beat1");

        // Interleaved burst from low bits 10, write
        order_sel = 1'b1;
        cyc(1'b0, 3'b111, 1'b1, 20'h0ABCE, "R2 load interleaved write");
        cyc(1'b1, 3'b111, 1'b0, 0, "R6 ilv beat1");
        cyc(1'b1, 3'b001, 1'b0, 0, "R6 R7 ilv beat2");
        cyc(1'b1, 3'b100, 1'b0, 0, "R6 ilv beat3");
        cyc(1'b1, 3'b000, 1'b0, 20'h55555, "R8 R7 wrap interleaved");

        // Reload in the middle of a burst
        cyc(1'b1, 3'b111, 1'b1, 0, "R6 before reload");
        cyc(1'b0, 3'b111, 1'b0, 20'hF0F03, "R2 mid-burst reload");
        cyc(1'b1, 3'b111, 1'b0, 0, "R6 after reload");

        // Deselecting load then idle advances
        cyc(1'b0, 3'b011, 1'b1, 20'h33333, "R3 deselect");
        cyc(1'b1, 3'b111, 1'b1, 20'h44444, "R9 idle advance");
        cyc(1'b1, 3'b111, 1'b0, 0, "R9 idle advance again");
        cyc(1'b0, 3'b110, 1'b1, 0, "R3 deselect from idle");
        cyc(1'b1, 3'b000, 1'b0, 0, "R9 idle hold");

        // Sweep every start value in both orders
        for (int m = 0; m < 2; m++) begin
            order_sel = logic'(m);
            for (int s = 0; s < 4; s++) begin
                cyc(1'b0, 3'b111, logic'(s & 1), 20'hA5A50 + s, "R2 sweep load");
                for (int k = 0; k < 5; k++) begin
                    cyc(1'b1, 3'b111, 1'b0, 0, m ? "R6 sweep" : "R5 sweep");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule